// File: doc/BRIEF.md
# SRAM Power-Up Stability Classifier

This block sorts the cells of an SRAM region into stable and unstable positions by looking at several power-up captures of that region. Each capture arrives as a stream of words tagged with a word address, and an end-of-capture strobe closes it. The first capture after a start strobe becomes the reference. Every later capture adds one to a saturating per-bit counter wherever it disagrees with the reference.

Once the programmed number of captures has been closed, the block classes each bit. A bit is stable when its disagreement count does not exceed a programmable allowance, which is normally zero. The block then pulses a completion flag and presents the number of stable bits and the number of unstable bits. On request, it streams the stability mask out one word per cycle under a valid/ready handshake. A 1 in the mask marks a stable cell, which key and identifier logic can use. A 0 marks an unstable cell, which a random-seed collector can use as an entropy source.

Top module: `puf_stable_classifier`

## Requirements
- R1: After reset, `done`, `mask_valid` and both totals are 0.
- R2: The first capture after `start` is the reference. A bit that matches the reference in every later capture has mask value 1 (stable) when the allowance is 0.
- R3: Each per-bit disagreement counter saturates at 2^CNT_W-1 and never wraps. With the defaults and allowance 0, a bit that disagrees in 16 captures is still unstable.
- R4: A bit is stable exactly when its disagreement count is less than or equal to `cfg_allow`. Both `cfg_allow` and `cfg_snaps` are sampled on `start`, and a `cfg_snaps` value of 0 acts as 1.
- R5: The final end-of-capture strobe is sampled on clock edge k. `done` is 1 after edge k+1 only, and at that point `stable_total + unstable_total` equals the number of bits in the region.
- R6: `start` clears every counter and both totals, and ends any readout in progress. From the cycle after `start`, both totals read 0.
- R7: A `rd_start` pulse after completion streams mask words at addresses 0 up to NUM_WORDS-1 in order. Each word is accepted on an edge where `mask_valid` and `mask_ready` are both 1. While `mask_ready` is 0, the data and address hold. `mask_last` is 1 on the final word. Mask bit i of word a describes region bit a*WORD_W+i.
- R8: Words and end-of-capture strobes that arrive after completion and before the next `start` are ignored. They change neither the totals nor the mask, and they raise no `done`.
- R9: With one capture programmed, every bit is classed stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new enrollment, clearing all state |
| cfg_snaps | input | SNAP_W | Number of captures to take |
| cfg_allow | input | CNT_W | Largest disagreement count still classed stable |
| in_valid | input | 1 | Capture word present |
| in_addr | input | AW | Word address of the capture word |
| in_data | input | WORD_W | Capture word |
| snap_end | input | 1 | Closes the current capture |
| done | output | 1 | One-cycle completion pulse |
| stable_total | output | TOT_W | Number of stable bits |
| unstable_total | output | TOT_W | Number of unstable bits |
| rd_start | input | 1 | Request a mask readout |
| mask_valid | output | 1 | Mask word present |
| mask_ready | input | 1 | Consumer accepts the mask word |
| mask_addr | output | AW | Word address of the mask word |
| mask_data | output | WORD_W | Mask word, 1 = stable |
| mask_last | output | 1 | Final mask word |

## Verification
Captures are driven in four patterns, each aimed at a different part of the design:
- A sparse random set of cells toggles at random, with about 5% of cells flipping. This checks that the reference comparison, the counting and the totals match a bench model.
- One cell flips in every capture over 17 captures. This separates a saturating counter from a wrapping one.
- Every cell flips with probability one in four, combined with a nonzero allowance. This checks the less-or-equal threshold at many different counts.
- No cell flips, run right after an unstable enrollment. This shows that `start` really clears the counters.

In addition, a single-capture run, captures fed after completion, and readouts with a randomly stalling `mask_ready` cover the remaining corner cases.

// File: rtl/puf_cls_pkg.sv
package puf_cls_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ENROLL = 2'd1,
    PH_CLASS  = 2'd2,
    PH_READY  = 2'd3
  } phase_t;
endpackage

// File: rtl/puf_flip_bank.sv
module puf_flip_bank #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int CNT_W     = 4,
  parameter int AW        = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          cap_ref,
  input  logic                          cap_cmp,
  input  logic [AW-1:0]                 addr,
  input  logic [WORD_W-1:0]             data,
  input  logic [CNT_W-1:0]              allow,
  output logic [NUM_WORDS*WORD_W-1:0]   stable_vec
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic keep_bit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lim);
    return c <= lim;
  endfunction

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] ref_q;
    logic              hit;
    logic [WORD_W-1:0] diff;

    assign hit  = (addr == AW'(w));
    assign diff = ref_q ^ data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ref_q <= '0;
      else if (cap_ref && hit) ref_q <= data;
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clear)                    cnt_q <= '0;
        else if (cap_cmp && hit && diff[b]) cnt_q <= sat_inc(cnt_q);
      end
      assign stable_vec[w*WORD_W + b] = keep_bit(cnt_q, allow);
    end
  end
endmodule

// File: rtl/puf_tally.sv
module puf_tally #(
  parameter int NUM_BITS = 128,
  parameter int TOT_W    = 8
) (
  input  logic [NUM_BITS-1:0] vec,
  output logic [TOT_W-1:0]    ones,
  output logic [TOT_W-1:0]    zeros
);
  function automatic logic [TOT_W-1:0] pop(input logic [NUM_BITS-1:0] v);
    logic [TOT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_BITS; i++) acc = acc + TOT_W'(v[i]);
    return acc;
  endfunction

  assign ones  = pop(vec);
  assign zeros = TOT_W'(NUM_BITS) - ones;
endmodule

// File: rtl/puf_mask_reader.sv
module puf_mask_reader #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int AW        = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic                        abort,
  input  logic [NUM_WORDS*WORD_W-1:0] vec,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic [AW-1:0]               m_addr,
  output logic [WORD_W-1:0]           m_data,
  output logic                        m_last
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_WORDS - 1);

  logic          active_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && m_ready) begin
      if (idx_q == LAST_IDX) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  assign m_valid = active_q;
  assign m_addr  = idx_q;
  assign m_data  = vec[idx_q*WORD_W +: WORD_W];
  assign m_last  = active_q && (idx_q == LAST_IDX);
endmodule

// File: rtl/puf_stable_classifier.sv
module puf_stable_classifier
  import puf_cls_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int CNT_W     = 4,
  parameter int SNAP_W    = 8,
  localparam int AW       = $clog2(NUM_WORDS),
  localparam int NUM_BITS = NUM_WORDS * WORD_W,
  localparam int TOT_W    = $clog2(NUM_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SNAP_W-1:0] cfg_snaps,
  input  logic [CNT_W-1:0]  cfg_allow,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic              snap_end,
  output logic              done,
  output logic [TOT_W-1:0]  stable_total,
  output logic [TOT_W-1:0]  unstable_total,
  input  logic              rd_start,
  output logic              mask_valid,
  input  logic              mask_ready,
  output logic [AW-1:0]     mask_addr,
  output logic [WORD_W-1:0] mask_data,
  output logic              mask_last
);
  phase_t            phase_q;
  logic [SNAP_W-1:0] snap_idx_q;
  logic [SNAP_W-1:0] n_cfg_q;
  logic [CNT_W-1:0]  allow_q;
  logic [NUM_BITS-1:0] stable_vec;
  logic [TOT_W-1:0]  ones_w, zeros_w;

  // named events for the checker
  logic word_taken, snap_closed, last_snap, class_fire, read_go;

  assign word_taken  = in_valid && (phase_q == PH_ENROLL) && !start;
  assign snap_closed = snap_end && (phase_q == PH_ENROLL) && !start;
  assign last_snap   = snap_closed && ({1'b0, snap_idx_q} + 1'b1 >= {1'b0, n_cfg_q});
  assign class_fire  = (phase_q == PH_CLASS) && !start;
  assign read_go     = rd_start && (phase_q == PH_READY) && !mask_valid && !start;

  puf_flip_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .cap_ref(word_taken && (snap_idx_q == '0)),
    .cap_cmp(word_taken && (snap_idx_q != '0)),
    .addr(in_addr), .data(in_data), .allow(allow_q),
    .stable_vec(stable_vec)
  );

  puf_tally #(.NUM_BITS(NUM_BITS), .TOT_W(TOT_W)) u_tally (
    .vec(stable_vec), .ones(ones_w), .zeros(zeros_w)
  );

  puf_mask_reader #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_n), .go(read_go), .abort(start), .vec(stable_vec),
    .m_valid(mask_valid), .m_ready(mask_ready), .m_addr(mask_addr),
    .m_data(mask_data), .m_last(mask_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q        <= PH_IDLE;
      snap_idx_q     <= '0;
      n_cfg_q        <= '0;
      allow_q        <= '0;
      done           <= 1'b0;
      stable_total   <= '0;
      unstable_total <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        phase_q        <= PH_ENROLL;
        snap_idx_q     <= '0;
        n_cfg_q        <= (cfg_snaps == '0) ? SNAP_W'(1) : cfg_snaps;
        allow_q        <= cfg_allow;
        stable_total   <= '0;
        unstable_total <= '0;
      end else if (snap_closed) begin
        snap_idx_q <= snap_idx_q + 1'b1;
        if (last_snap) phase_q <= PH_CLASS;
      end else if (class_fire) begin
        stable_total   <= ones_w;
        unstable_total <= zeros_w;
        done           <= 1'b1;
        phase_q        <= PH_READY;
      end
    end
  end
endmodule

// File: rtl/puf_cls_checker.sv
module puf_cls_checker #(
  parameter int NUM_BITS = 128,
  parameter int TOT_W    = 8,
  parameter int WORD_W   = 8,
  parameter int AW       = 4,
  parameter int NUM_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              class_fire,
  input logic [TOT_W-1:0]  stable_total,
  input logic [TOT_W-1:0]  unstable_total,
  input logic              mask_valid,
  input logic              mask_ready,
  input logic [AW-1:0]     mask_addr,
  input logic [WORD_W-1:0] mask_data,
  input logic              mask_last
);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_totals_sum: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(stable_total) + 32'(unstable_total) == 32'(NUM_BITS)));

  a_r5_done_follows_class: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(class_fire));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && stable_total == '0 && unstable_total == '0 && !mask_valid));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_valid && !mask_ready && !start) |=>
      (mask_valid && $stable(mask_data) && $stable(mask_addr)));

  a_r7_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mask_last |-> (mask_valid && 32'(mask_addr) == NUM_WORDS - 1));
endmodule

bind puf_stable_classifier puf_cls_checker #(
  .NUM_BITS(NUM_BITS), .TOT_W(TOT_W), .WORD_W(WORD_W), .AW(AW), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .class_fire(class_fire),
  .stable_total(stable_total), .unstable_total(unstable_total),
  .mask_valid(mask_valid), .mask_ready(mask_ready), .mask_addr(mask_addr),
  .mask_data(mask_data), .mask_last(mask_last)
);

// File: tb/puf_stable_classifier_bench.sv
module puf_stable_classifier_bench;
  localparam int WORD_W = 8, NUM_WORDS = 16, CNT_W = 4, SNAP_W = 8;
  localparam int AW = 4, NUM_BITS = 128, TOT_W = 8;
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic start = 0, in_valid = 0, snap_end = 0, rd_start = 0, mask_ready = 0;
  logic [SNAP_W-1:0] cfg_snaps = '0;
  logic [CNT_W-1:0]  cfg_allow = '0;
  logic [AW-1:0]     in_addr = '0;
  logic [WORD_W-1:0] in_data = '0;
  logic done, mask_valid, mask_last;
  logic [TOT_W-1:0] stable_total, unstable_total;
  logic [AW-1:0] mask_addr;
  logic [WORD_W-1:0] mask_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [WORD_W-1:0] refw [NUM_WORDS];
  int cnt [NUM_BITS];
  bit unst_sel [NUM_BITS];
  int cur_allow;

  always #10 clk = ~clk;

  puf_stable_classifier u_puf_stable_classifier (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_snaps(cfg_snaps), .cfg_allow(cfg_allow),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data), .snap_end(snap_end),
    .done(done), .stable_total(stable_total), .unstable_total(unstable_total),
    .rd_start(rd_start), .mask_valid(mask_valid), .mask_ready(mask_ready),
    .mask_addr(mask_addr), .mask_data(mask_data), .mask_last(mask_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_stable(input int b);
    return cnt[b] <= cur_allow;
  endfunction

  function automatic int exp_stable_count();
    int n = 0;
    for (int b = 0; b < NUM_BITS; b++) n += exp_stable(b);
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(input int w);
    logic [WORD_W-1:0] v;
    for (int i = 0; i < WORD_W; i++) v[i] = exp_stable(w*WORD_W + i);
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] flip_mask(input int mode, input int w);
    logic [WORD_W-1:0] m = '0;
    case (mode)
      0: for (int i = 0; i < WORD_W; i++)
           m[i] = unst_sel[w*WORD_W+i] && ($urandom_range(1) == 1);
      1: m = (w == 3) ? 8'h20 : 8'h00;
      2: m = WORD_W'($urandom) & WORD_W'($urandom);
      default: m = '0;
    endcase
    return m;
  endfunction

  task automatic send_word(input int w, input logic [WORD_W-1:0] d);
    in_valid = 1; in_addr = AW'(w); in_data = d;
    @(negedge clk);
    in_valid = 0;
    if ($urandom_range(3) == 0) @(negedge clk);
  endtask

  task automatic enroll(input int n, input int allow, input int mode);
    cfg_snaps = SNAP_W'(n); cfg_allow = CNT_W'(allow); cur_allow = allow;
    start = 1; @(negedge clk); start = 0;
    check(stable_total == 0 && unstable_total == 0, "R6 totals cleared", stable_total, 0);
    for (int b = 0; b < NUM_BITS; b++) begin
      cnt[b] = 0;
      unst_sel[b] = ($urandom_range(19) == 0);
    end
    for (int s = 0; s < n; s++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        logic [WORD_W-1:0] d, fm;
        if (s == 0) begin
          d = WORD_W'($urandom); refw[w] = d;
        end else begin
          fm = flip_mask(mode, w);
          d = refw[w] ^ fm;
          for (int i = 0; i < WORD_W; i++)
            if (fm[i] && cnt[w*WORD_W+i] < SAT) cnt[w*WORD_W+i]++;
        end
        send_word(w, d);
      end
      snap_end = 1; @(negedge clk); snap_end = 0;
      if (s == n-1) begin
        check(done == 0, "R5 done not early", done, 0);
        @(negedge clk);
        check(done == 1, "R5 done on time", done, 1);
        check(stable_total == exp_stable_count(), "R5 R4 stable total",
              stable_total, exp_stable_count());
        check(unstable_total == NUM_BITS - exp_stable_count(), "R5 unstable total",
              unstable_total, NUM_BITS - exp_stable_count());
        @(negedge clk);
        check(done == 0, "R5 done one cycle", done, 0);
      end else begin
        check(done == 0, "R5 no done mid enrollment", done, 0);
      end
    end
  endtask

  task automatic readout(input string req);
    int got = 0;
    int guard = 0;
    rd_start = 1; @(negedge clk); rd_start = 0;
    while (got < NUM_WORDS && guard < 400) begin
      guard++;
      if (mask_valid) begin
        check(mask_addr == AW'(got), {req, " R7 order"}, mask_addr, got);
        check(mask_data == exp_word(got), {req, " mask word"}, mask_data, exp_word(got));
        check(mask_last == (got == NUM_WORDS-1), "R7 last flag", mask_last, got == NUM_WORDS-1);
      end
      mask_ready = ($urandom_range(2) != 0);
      if (mask_ready && mask_valid) got++;
      @(negedge clk);
      mask_ready = 0;
    end
    check(got == NUM_WORDS, "R7 word count", got, NUM_WORDS);
    check(mask_valid == 0, "R7 valid drops after last", mask_valid, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(done == 0 && mask_valid == 0 && stable_total == 0 && unstable_total == 0,
          "R1 reset state", {done, mask_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(done == 0 && stable_total == 0, "R1 after release", stable_total, 0);

    // R2 R4: sparse random unstable cells
    enroll(6, 0, 0);
    readout("R2");

    // R8: captures after completion are ignored
    for (int w = 0; w < NUM_WORDS; w++) send_word(w, ~refw[w]);
    snap_end = 1; @(negedge clk); snap_end = 0;
    for (int k = 0; k < 4; k++) begin
      check(done == 0, "R8 no done after completion", done, 0);
      @(negedge clk);
    end
    check(stable_total == exp_stable_count(), "R8 totals unchanged", stable_total, exp_stable_count());
    readout("R8");

    // R3: one cell disagrees 16 times, allowance 0
    enroll(17, 0, 1);
    check(stable_total == NUM_BITS - 1, "R3 saturated cell unstable", stable_total, NUM_BITS - 1);
    readout("R3");

    // R4: threshold with nonzero allowance
    enroll(8, 3, 2);
    readout("R4");

    // R9: single capture
    enroll(1, 0, 0);
    check(stable_total == NUM_BITS, "R9 all stable", stable_total, NUM_BITS);

    // R6: fresh start after unstable run
    enroll(9, 0, 2);
    enroll(2, 0, 3);
    check(stable_total == NUM_BITS, "R6 counters cleared", stable_total, NUM_BITS);
    readout("R6");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule